// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block drives a low-power, single-channel sampling converter over a three-wire serial link: an active-low chip select, a serial clock and a serial data return line. A frame starts when chip select goes low. That edge also wakes the converter and starts its conversion. The controller then issues a fixed number of serial clock cycles and shifts in one bit on each falling edge. It raises chip select as soon as the last falling edge has occurred, which puts the converter back to sleep. The 12-bit result is presented on a parallel output together with a one-cycle valid strobe.

Three frame lengths are supported: 16, 14 and 12 clocks. In the longer frames the leading bits are zeros, and the result is always taken from the last twelve bits received. A quiet gap, counted in system clocks, is enforced after every frame. A start request that arrives during a frame or during the quiet gap is remembered and served as soon as the gap ends. An abort input ends a running frame early by raising chip select, and the frame is reported as invalid. After reset, the controller runs one discarded frame without being asked, so that the converter is left asleep and in hold before any real request is served.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, chip select and serial clock are high and no strobe is active. A discarded frame then runs without a start request, using the selected length, and it raises neither the valid strobe nor the abort strobe.
- R2: `frame_len_i` encodes the frame length as follows: 1 gives 14 falling serial clock edges, 2 gives 12, and 0 or 3 give 16. A completed frame produces exactly that many falling edges while chip select is low.
- R3: The serial clock is high whenever chip select is high. Its first falling edge comes DIV_HALF system clocks after chip select falls, and each later falling edge comes 2*DIV_HALF system clocks after the one before it.
- R4: Data is sampled at each falling serial clock edge, most significant bit first. The result equals the last 12 bits received, so the leading bits of a 14- or 16-clock frame are dropped.
- R5: Chip select rises one system clock after the last falling edge of a frame. `result_valid_o` pulses for one cycle, in the first cycle in which chip select is high, and carries the new result.
- R6: When `abort_i` is high during a frame that has not yet had its last falling edge, chip select rises at the next clock edge. `frame_abort_o` pulses for one cycle, and no valid strobe is given for that frame.
- R7: After chip select rises, it stays high for at least QUIET_CYC+1 system clocks, and `busy_o` stays high during the quiet gap.
- R8: A start request made during a frame or during the quiet gap is held. Chip select then falls exactly QUIET_CYC+1 cycles after it rose.
- R9: `abort_i` while no frame is running has no effect: chip select stays high and no abort strobe is given.
- R10: `busy_o` is high whenever chip select is low. It is low only when the controller is idle and nothing is pending.
- R11: The frame length is captured when chip select falls. Changing `frame_len_i` during a frame does not change the number of falling edges in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion frame |
| abort_i | input | 1 | End the running frame early |
| frame_len_i | input | 2 | Frame length select (0/3:16, 1:14, 2:12) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame, quiet gap or request in progress |
| result_o | output | 12 | Last completed conversion result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| frame_abort_o | output | 1 | One-cycle strobe for an aborted frame |

## Verification
The first falling serial edge is due DIV_HALF cycles after chip select falls, and the falling edges after it are 2*DIV_HALF cycles apart. The result strobe is due one cycle after the last falling edge, in the same cycle chip select rises. An abort raises chip select one cycle after the cycle in which the abort was seen. A held request lowers chip select again exactly QUIET_CYC+1 cycles after it rose. A monitor samples every port at the falling system clock edge and stamps each event with a cycle number, and the checks compare those cycle stamps and the counts of falling edges with these offsets. A behavioural converter model drives each bit of a random pattern after each falling serial edge, and the result is compared with the low 12 bits of that pattern.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int FRAME_MAX = 16;
  localparam int RES_W     = 12;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } ctrl_st_e;

  // Length select -> number of falling serial edges in one frame.
  function automatic logic [CNT_W-1:0] frame_clocks(input logic [1:0] sel);
    case (sel)
      2'd1:    return CNT_W'(14);
      2'd2:    return CNT_W'(12);
      default: return CNT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_q,
  output logic fall_evt
);
  localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(DIV_HALF - 1);

  logic [HC_W-1:0] hc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      sclk_q <= 1'b1;
    end else if (!run) begin
      hc_q   <= '0;
      sclk_q <= 1'b1;
    end else if (hc_q == HC_LAST) begin
      hc_q   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hc_q   <= hc_q + HC_W'(1);
    end
  end

  // High in the cycle whose closing edge drives the serial clock low.
  assign fall_evt = run && sclk_q && (hc_q == HC_LAST);

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift
  import adc_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp,
  input  logic             sdata,
  output logic [RES_W-1:0] word,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      word <= '0;
      cnt  <= '0;
    end else if (smp) begin
      word <= {word[RES_W-2:0], sdata};
      cnt  <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_quiet_timer.sv
module adc_quiet_timer #(
  parameter int QUIET_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUIET_CYC - 1);

  logic [QW-1:0] qc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          qc_q <= '0;
    else if (!run)       qc_q <= '0;
    else if (!expired)   qc_q <= qc_q + QW'(1);
  end

  assign expired = run && (qc_q == Q_LAST);
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int DIV_HALF  = 4,
  parameter int QUIET_CYC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [1:0]       frame_len_i,
  input  logic             sdata_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o,
  output logic             frame_abort_o
);
  ctrl_st_e          st_q;
  logic              cs_n_q;
  logic [CNT_W-1:0]  len_q;
  logic              dummy_pend_q;
  logic              dummy_q;
  logic              pend_q;
  logic [RES_W-1:0]  res_q;
  logic              val_q;
  logic              abo_q;

  logic              sclk_q;
  logic              fall_evt;
  logic [RES_W-1:0]  rx_word;
  logic [CNT_W-1:0]  rx_cnt;
  logic              quiet_exp;

  // Named internal events
  logic frame_start_w;
  logic frame_done_w;
  logic frame_abort_w;

  assign frame_start_w = (st_q == ST_IDLE) && (dummy_pend_q || pend_q || start_i);
  // Completion one cycle after the last fall, so that edge happens with CS low.
  assign frame_done_w  = (st_q == ST_FRAME) && (rx_cnt == len_q);
  assign frame_abort_w = (st_q == ST_FRAME) && abort_i && !frame_done_w;

  adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q == ST_FRAME),
    .sclk_q   (sclk_q),
    .fall_evt (fall_evt)
  );

  adc_rx_shift u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_start_w),
    .smp   (fall_evt && (rx_cnt != len_q)),
    .sdata (sdata_i),
    .word  (rx_word),
    .cnt   (rx_cnt)
  );

  adc_quiet_timer #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == ST_QUIET),
    .expired (quiet_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      cs_n_q       <= 1'b1;
      len_q        <= CNT_W'(FRAME_MAX);
      dummy_pend_q <= 1'b1;
      dummy_q      <= 1'b0;
      pend_q       <= 1'b0;
      res_q        <= '0;
      val_q        <= 1'b0;
      abo_q        <= 1'b0;
    end else begin
      val_q <= 1'b0;
      abo_q <= 1'b0;
      if (frame_start_w && !dummy_pend_q) pend_q <= 1'b0;
      else if (start_i)                   pend_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (frame_start_w) begin
            st_q         <= ST_FRAME;
            cs_n_q       <= 1'b0;
            len_q        <= frame_clocks(frame_len_i);
            dummy_q      <= dummy_pend_q;
            dummy_pend_q <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (frame_done_w) begin
            st_q   <= ST_QUIET;
            cs_n_q <= 1'b1;
            val_q  <= !dummy_q;
            if (!dummy_q) res_q <= rx_word;
          end else if (frame_abort_w) begin
            st_q   <= ST_QUIET;
            cs_n_q <= 1'b1;
            abo_q  <= !dummy_q;
          end
        end
        ST_QUIET: begin
          if (quiet_exp) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o         = cs_n_q;
  assign sclk_o         = sclk_q | cs_n_q;
  assign busy_o         = (st_q != ST_IDLE) || dummy_pend_q || pend_q;
  assign result_o       = res_q;
  assign result_valid_o = val_q;
  assign frame_abort_o  = abo_q;

endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int QUIET_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_o,
  input logic       sclk_o,
  input logic       busy_o,
  input logic       result_valid_o,
  input logic       frame_abort_o,
  input logic       frame_abort_w,
  input logic [4:0] len_q
);
  localparam int HI_SAT = 1 << 20;

  int         hi_cnt;
  logic [4:0] fcnt;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HI_SAT;
      fcnt   <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_d <= sclk_o;
      if (cs_n_o) begin
        hi_cnt <= (hi_cnt < HI_SAT) ? hi_cnt + 1 : hi_cnt;
        fcnt   <= '0;
      end else begin
        hi_cnt <= 0;
        if (sclk_d && !sclk_o) fcnt <= fcnt + 5'd1;
      end
    end
  end

  a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  a_r5_valid_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (cs_n_o && !$past(cs_n_o)));

  a_r6_abort_raises_cs: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort_w |=> cs_n_o);

  a_r6_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid_o && frame_abort_o));

  a_r7_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt > QUIET_CYC));

  a_r10_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  a_r2_fall_count: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (fcnt == len_q));

endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cs_n_o         (cs_n_o),
  .sclk_o         (sclk_o),
  .busy_o         (busy_o),
  .result_valid_o (result_valid_o),
  .frame_abort_o  (frame_abort_o),
  .frame_abort_w  (frame_abort_w),
  .len_q          (len_q)
);

// File: tb/adc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb;
  localparam int DIV = 2;
  localparam int QC  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        abort_i = 1'b0;
  logic [1:0]  frame_len_i = 2'd2;
  logic        sdata_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, result_valid_o, frame_abort_o;
  logic [11:0] result_o;

  always #2.5 clk = ~clk;

  adc_frame_ctrl #(.DIV_HALF(DIV), .QUIET_CYC(QC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .frame_len_i(frame_len_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .busy_o(busy_o), .result_o(result_o),
    .result_valid_o(result_valid_o), .frame_abort_o(frame_abort_o)
  );

  int  nchk = 0, nbad = 0;
  bit  finished = 0;

  function automatic int len_of(int m);
    return (m == 1) ? 14 : (m == 2) ? 12 : 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: first bit after CS falls, next bit after each falling SCLK.
  logic [15:0] pat = 16'h0;
  int          cur_n = 12;
  initial begin : conv_model
    forever begin
      int k;
      @(negedge cs_n_o);
      k = 0;
      #1 sdata_i = pat[cur_n-1];
      while (!cs_n_o) begin
        @(negedge sclk_o or posedge cs_n_o);
        if (cs_n_o) break;
        k++;
        #1 if (k < cur_n) sdata_i = pat[cur_n-1-k];
      end
    end
  end

  // Port monitor, sampled away from the active edge.
  int cyc = 0, cs_fall_cnt = 0, cs_rise_cnt = 0, falls = 0, last_falls = 0;
  int hi_run = 0, last_hi_run = 0, fall_cyc = 0, first_fall_delay = 0, prev_fall_cyc = 0;
  int bad_period = 0, bad_idle = 0, bad_busy = 0, abort_cyc = 0, rise_cyc = 0;
  int got_valid = 0, got_abort = 0, res_seen = 0;
  bit valid_on_rise = 0, pcs = 1, psclk = 1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pcs && !cs_n_o) begin
        cs_fall_cnt++; last_hi_run = hi_run; hi_run = 0; falls = 0; fall_cyc = cyc;
      end
      if (!pcs && cs_n_o) begin
        cs_rise_cnt++; last_falls = falls; rise_cyc = cyc;
      end
      if (cs_n_o) hi_run++;
      if (!cs_n_o && psclk && !sclk_o) begin
        falls++;
        if (falls == 1) first_fall_delay = cyc - fall_cyc;
        else if (cyc - prev_fall_cyc != 2*DIV) bad_period++;
        prev_fall_cyc = cyc;
      end
      if (cs_n_o && !sclk_o) bad_idle++;
      if (!cs_n_o && !busy_o) bad_busy++;
      if (abort_i && !cs_n_o) abort_cyc = cyc;
      if (result_valid_o) begin
        got_valid++; res_seen = int'(result_o); valid_on_rise = cs_n_o && !pcs;
      end
      if (frame_abort_o) got_abort++;
    end
    pcs = cs_n_o; psclk = sclk_o;
  end

  task automatic do_frame(input int mode, input int gap, input int abort_at, input int newmode);
    int bf, br, gv, ga, n;
    bit was_busy;
    repeat (gap) @(posedge clk);
    #1;
    n = len_of(mode);
    pat = 16'($urandom);
    cur_n = n;
    frame_len_i = 2'(mode);
    gv = got_valid; ga = got_abort; bf = cs_fall_cnt; br = cs_rise_cnt;
    start_i = 1'b1;
    was_busy = busy_o;
    @(posedge clk); #1 start_i = 1'b0;
    while (cs_fall_cnt == bf) @(negedge clk);
    if (newmode >= 0) begin
      repeat (3) @(posedge clk);
      #1 frame_len_i = 2'(newmode);
    end
    if (abort_at >= 1) begin
      repeat (abort_at) @(posedge clk);
      #1 abort_i = 1'b1;
      @(posedge clk); #1 abort_i = 1'b0;
    end
    while (cs_rise_cnt == br) @(negedge clk);
    repeat (2) @(negedge clk);
    if (abort_at >= 1) begin
      chk(got_abort == ga + 1, "R6 abort strobe", got_abort - ga, 1);
      chk(got_valid == gv, "R6 no result on abort", got_valid - gv, 0);
      chk(rise_cyc == abort_cyc + 1, "R6 cs rise after abort", rise_cyc - abort_cyc, 1);
      chk(last_falls < n, "R6 frame cut short", last_falls, n);
    end else begin
      chk(got_valid == gv + 1, "R5 one valid strobe", got_valid - gv, 1);
      chk(valid_on_rise, "R5 strobe in first cs-high cycle", int'(valid_on_rise), 1);
      chk(res_seen == int'(pat[11:0]), "R4 result bits", res_seen, int'(pat[11:0]));
      if (newmode >= 0)
        chk(last_falls == n, "R11 length held during frame", last_falls, n);
      else
        chk(last_falls == n, "R2 falling edge count", last_falls, n);
      chk(got_abort == ga, "R6 no abort strobe", got_abort - ga, 0);
    end
    if (was_busy)
      chk(last_hi_run == QC + 1, "R8 held start timing", last_hi_run, QC + 1);
    else
      chk(last_hi_run >= QC + 1, "R7 quiet gap", last_hi_run, QC + 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1d7a5));
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 reset cs high", int'(cs_n_o), 1);
    chk(sclk_o == 1'b1, "R1 reset sclk high", int'(sclk_o), 1);
    chk(result_valid_o == 1'b0 && frame_abort_o == 1'b0, "R1 reset no strobe",
        int'(result_valid_o), 0);
    rst_n = 1'b1;

    // Discarded frame after reset, 12-clock length selected.
    while (cs_rise_cnt == 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(last_falls == 12, "R1 dummy frame length", last_falls, 12);
    chk(got_valid == 0, "R1 dummy gives no result", got_valid, 0);
    chk(got_abort == 0, "R1 dummy gives no abort", got_abort, 0);
    chk(first_fall_delay == DIV, "R3 first fall delay", first_fall_delay, DIV);
    chk(busy_o == 1'b1, "R7 busy during quiet", int'(busy_o), 1);
    repeat (QC + 2) @(negedge clk);
    chk(busy_o == 1'b0, "R10 busy low when idle", int'(busy_o), 0);

    // Abort while idle.
    @(posedge clk); #1 abort_i = 1'b1;
    @(posedge clk); #1 abort_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(got_abort == 0, "R9 idle abort ignored", got_abort, 0);
    chk(cs_n_o == 1'b1, "R9 cs stays high", int'(cs_n_o), 1);

    // Directed frames.
    do_frame(0, 0, -1, -1);
    do_frame(1, 0, -1, -1);
    do_frame(2, 0, -1, -1);
    do_frame(3, 8, -1, -1);
    do_frame(1, 0, -1, 2);
    do_frame(2, 0, -1, 0);
    do_frame(0, 0, 5, -1);
    do_frame(2, 0, 1, -1);

    // Random mix.
    for (int i = 0; i < 60; i++) begin
      int m, g, a;
      m = int'($urandom % 4);
      g = int'($urandom % 10);
      a = (($urandom % 4) == 0) ? 1 + int'($urandom % (20*DIV)) : -1;
      do_frame(m, g, a, -1);
    end

    chk(bad_idle == 0, "R3 sclk high while cs high", bad_idle, 0);
    chk(bad_period == 0, "R3 falling edge spacing", bad_period, 0);
    chk(bad_busy == 0, "R10 busy while cs low", bad_busy, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule